// File: doc/BRIEF.md
# Variable-Length Serial Slave Transceiver

This block is a three-wire synchronous serial port that works only as a slave. A remote master supplies the shift clock on an input pin; the block never drives it. Each frame moves one transmit word out and one receive word in at the same time. The frame length is chosen by a small code, from 8 up to 16 bits, and a control bit picks whether the most or the least significant bit travels first.

Software starts a frame by writing the transmit word. The write raises a busy flag, and the block then waits for the master's clock edges. Output data changes on falling serial clock edges. Input data is sampled on rising edges. On the rising edge that carries the last bit, the block clears busy and gives a one-cycle completion pulse. If reception is enabled, it also stores the received bits right-aligned in the receive register. That register holds its value until the next frame completes. The frame length and bit order are latched when the write is accepted.

The serial pins are resynchronised into the system clock domain, and edges are found there. For that reason the system clock must run at least four times faster than the serial clock. Clearing the power bit returns the shifter to idle.

Top module: `serial_slave_xcvr`

## Requirements
- R1: During and directly after reset, `xfer_busy`, `done_irq` and `sdo_pin` are 0 and `rxd_data` is all zeros.
- R2: A `txd_wr` pulse while `cfg_power` is 1 and the block is idle sets `xfer_busy`. From then on, `sdo_pin` shows the first bit of the word, provided `cfg_tx_en` is 1.
- R3: The frame length follows `cfg_len_code`, with codes 9 to 15 clamped to the maximum:
  - code 0 selects 8 bits;
  - codes 1 to 8 select 8 plus the code (9 to 16 bits);
  - codes 9 to 15 select 16 bits.
- R4: With `cfg_lsb_first` = 0, the word is sent starting from bit N-1 and going down to bit 0, where N is the frame length. The first bit received lands in bit N-1 of `rxd_data`, and the last bit received lands in bit 0.
- R5: With `cfg_lsb_first` = 1, the word is sent starting from bit 0 and going up. The first bit received lands in bit 0 of `rxd_data`.
- R6: On the rising serial edge that carries bit N, `done_irq` pulses for exactly one system cycle and `xfer_busy` clears. At the same time, `rxd_data` takes the received word with bits above N-1 zero. `rxd_data` changes at no other time.
- R7: While `xfer_busy` is 0, serial clock edges have no effect. `sdo_pin` stays 0, no pulse occurs, and `rxd_data` keeps its value.
- R8: A `txd_wr` pulse while `xfer_busy` is 1 is ignored. The running frame continues with its original word and length.
- R9: Clearing `cfg_power` returns the block to idle (busy 0, `sdo_pin` 0, no pulse), and transmit writes are ignored while power is off. `rxd_data` keeps its value.
- R10: With `cfg_tx_en` = 0, `sdo_pin` stays 0 during a frame. With `cfg_rx_en` = 0, a frame still completes with a pulse, but `rxd_data` is not updated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_power | input | 1 | Block enable; 0 forces idle |
| cfg_tx_en | input | 1 | Allows data onto `sdo_pin` |
| cfg_rx_en | input | 1 | Allows update of `rxd_data` |
| cfg_lsb_first | input | 1 | 0: MSB first, 1: LSB first |
| cfg_len_code | input | LEN_W | Frame length code |
| txd_wr | input | 1 | One-cycle transmit write strobe |
| txd_wdata | input | DATA_W | Transmit word |
| rxd_data | output | DATA_W | Last completed receive word, right-aligned |
| xfer_busy | output | 1 | Frame in progress |
| done_irq | output | 1 | One-cycle completion pulse |
| sck_pin | input | 1 | Serial clock from the master |
| sdi_pin | input | 1 | Serial data in |
| sdo_pin | output | 1 | Serial data out |

## Verification
The bench builds the block with its defaults: a 16-bit shifter, a 4-bit length code, a base length of 8 and a two-flop synchroniser. With these values every code of the length field can be reached, including the 16-bit maximum and the clamped codes above 8. Random frames draw the code, the bit order and both data words, and the serial clock runs at eight system cycles per period. Directed frames cover a write during a frame, a power-off part way through a frame, edges with no frame running, and each enable bit held low.

// File: rtl/sxcv_pkg.sv
// Shared defaults and types for the serial slave transceiver.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sxcv_pkg;
    localparam int unsigned DEF_DATA_W   = 16;
    localparam int unsigned DEF_LEN_W    = 4;
    localparam int unsigned DEF_BASE_LEN = 8;
    localparam int unsigned DEF_SYNC     = 2;

    typedef enum logic {
        ORDER_MSB = 1'b0,
        ORDER_LSB = 1'b1
    } bit_order_e;
endpackage

// File: rtl/sxcv_pin_sync.sv
// Resynchronises the serial clock and data pins into the system clock
// domain and reports one-cycle rise and fall strobes of the serial clock.
// Assumes STAGES >= 2 and a system clock at least 4x the serial clock.
module sxcv_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_pin,
    input  logic sdi_pin,
    output logic sck_rise,
    output logic sck_fall,
    output logic sdi_bit
);
    logic [STAGES-1:0] sck_q;
    logic [STAGES-1:0] sdi_q;
    logic              sck_last;

    // Shift both pins through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q    <= '0;
            sdi_q    <= '0;
            sck_last <= 1'b0;
        end else begin
            sck_q    <= {sck_q[STAGES-2:0], sck_pin};
            sdi_q    <= {sdi_q[STAGES-2:0], sdi_pin};
            sck_last <= sck_q[STAGES-1];
        end
    end

    // Edge strobes; data is aligned with the clock through equal depth.
    always_comb begin
        sck_rise = sck_q[STAGES-1] & ~sck_last;
        sck_fall = ~sck_q[STAGES-1] & sck_last;
        sdi_bit  = sdi_q[STAGES-1];
    end
endmodule

// File: rtl/sxcv_frame_ctrl.sv
// Frame sequencer: decodes the length code, owns the busy flag and the
// bit counter, latches length and order at the start of each frame and
// issues the load, shift, sample and done strobes plus the pulse.
// Assumes the edge strobes are single-cycle and mutually exclusive.
module sxcv_frame_ctrl #(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned LEN_W    = 4,
    parameter int unsigned BASE_LEN = 8,
    localparam int unsigned CNT_W   = $clog2(DATA_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             power,
    input  logic             tx_wr,
    input  logic [LEN_W-1:0] len_code,
    input  logic             lsb_first,
    input  logic             sck_rise,
    input  logic             sck_fall,
    output logic             busy,
    output logic             load,
    output logic             shift,
    output logic             sample,
    output logic             done,
    output logic [CNT_W-1:0] len_now,
    output logic [CNT_W-1:0] len_run,
    output logic             lsb_run,
    output logic             irq
);
    localparam logic [CNT_W-1:0] W_C = CNT_W'(DATA_W);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] nbits_q;
    logic             lsb_q;
    logic             irq_q;
    logic             last;
    int unsigned      sum;

    // Decode the length code, clamping above the shifter width.
    always_comb begin
        sum = BASE_LEN + int'(len_code);
        if (len_code == '0)
            len_now = CNT_W'(BASE_LEN);
        else if (sum >= DATA_W)
            len_now = W_C;
        else
            len_now = CNT_W'(sum);
    end

    // Strobes derived from state and synchronised edges.
    always_comb begin
        last   = (cnt_q == nbits_q - CNT_W'(1));
        load   = power & tx_wr & ~busy_q;
        sample = power & busy_q & sck_rise;
        shift  = power & busy_q & sck_fall & (cnt_q != '0);
        done   = sample & last;
    end

    // Busy flag, bit counter, frame configuration and pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            nbits_q <= CNT_W'(BASE_LEN);
            lsb_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else if (!power) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= done;
            if (load) begin
                busy_q  <= 1'b1;
                cnt_q   <= '0;
                nbits_q <= len_now;
                lsb_q   <= lsb_first;
            end else if (sample) begin
                cnt_q <= cnt_q + CNT_W'(1);
                if (last)
                    busy_q <= 1'b0;
            end
        end
    end

    assign busy    = busy_q;
    assign len_run = nbits_q;
    assign lsb_run = lsb_q;
    assign irq     = irq_q;

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (power && tx_wr && !busy_q) |=> busy_q);
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q < nbits_q));
    assert_len_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (nbits_q >= CNT_W'(BASE_LEN) && nbits_q <= W_C));
    assert_pulse_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    assert_pulse_ends_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (!busy_q && $past(busy_q)));
    assert_wr_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && tx_wr) |=> ($stable(nbits_q) && $stable(lsb_q)));
    assert_power_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !power |=> (!busy_q && !irq_q));
endmodule

// File: rtl/sxcv_shifter.sv
// Transmit and receive shift registers. Loads the transmit word so that
// the first bit sits at the output tap for either order, shifts it on
// falling strobes, collects input bits on rising strobes and presents the
// received word right-aligned as it will stand after the current sample.
// Assumes load, shift and sample are never high in the same cycle.
module sxcv_shifter #(
    parameter int unsigned DATA_W = 16,
    localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic              sample,
    input  logic [DATA_W-1:0] load_word,
    input  logic [CNT_W-1:0]  load_len,
    input  logic              load_lsb,
    input  logic [CNT_W-1:0]  run_len,
    input  logic              run_lsb,
    input  logic              sdi_bit,
    output logic              sdo_bit,
    output logic [DATA_W-1:0] rx_word
);
    import sxcv_pkg::*;

    localparam logic [CNT_W-1:0] W_C = CNT_W'(DATA_W);

    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] rx_next;

    // Next receive contents and the right-aligned word derived from them.
    always_comb begin
        if (bit_order_e'(run_lsb) == ORDER_LSB) begin
            rx_next = {sdi_bit, rx_sh[DATA_W-1:1]};
            rx_word = rx_next >> (W_C - run_len);
        end else begin
            rx_next = {rx_sh[DATA_W-2:0], sdi_bit};
            rx_word = rx_next;
        end
        sdo_bit = (bit_order_e'(run_lsb) == ORDER_LSB) ? tx_sh[0] : tx_sh[DATA_W-1];
    end

    // Load, shift and capture the two registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
            rx_sh <= '0;
        end else if (load) begin
            tx_sh <= (bit_order_e'(load_lsb) == ORDER_LSB) ? load_word
                                                            : load_word << (W_C - load_len);
            rx_sh <= '0;
        end else begin
            if (shift)
                tx_sh <= (bit_order_e'(run_lsb) == ORDER_LSB) ? tx_sh >> 1 : tx_sh << 1;
            if (sample)
                rx_sh <= rx_next;
        end
    end

    assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(tx_sh));
    assert_rx_fresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (rx_sh == '0));
endmodule

// File: rtl/serial_slave_xcvr.sv
// Top of the variable-length serial slave transceiver. Wires the pin
// synchroniser, the frame sequencer and the shifter, gates the data-out
// pin and holds the receive register between completed frames.
// Assumes the system clock is at least 4x the external serial clock.
module serial_slave_xcvr #(
    parameter int unsigned DATA_W      = sxcv_pkg::DEF_DATA_W,
    parameter int unsigned LEN_W       = sxcv_pkg::DEF_LEN_W,
    parameter int unsigned BASE_LEN    = sxcv_pkg::DEF_BASE_LEN,
    parameter int unsigned SYNC_STAGES = sxcv_pkg::DEF_SYNC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_power,
    input  logic              cfg_tx_en,
    input  logic              cfg_rx_en,
    input  logic              cfg_lsb_first,
    input  logic [LEN_W-1:0]  cfg_len_code,
    input  logic              txd_wr,
    input  logic [DATA_W-1:0] txd_wdata,
    output logic [DATA_W-1:0] rxd_data,
    output logic              xfer_busy,
    output logic              done_irq,
    input  logic              sck_pin,
    input  logic              sdi_pin,
    output logic              sdo_pin
);
    localparam int unsigned CNT_W = $clog2(DATA_W + 1);

    logic              sck_rise, sck_fall, sdi_bit;
    logic              busy, load, shift, sample, done, lsb_run, irq, sdo_bit;
    logic [CNT_W-1:0]  len_now, len_run;
    logic [DATA_W-1:0] rx_word;
    logic [DATA_W-1:0] rxd_q;

    sxcv_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck_pin(sck_pin), .sdi_pin(sdi_pin),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi_bit(sdi_bit)
    );

    sxcv_frame_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W), .BASE_LEN(BASE_LEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .power(cfg_power), .tx_wr(txd_wr),
        .len_code(cfg_len_code), .lsb_first(cfg_lsb_first),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .busy(busy), .load(load), .shift(shift), .sample(sample), .done(done),
        .len_now(len_now), .len_run(len_run), .lsb_run(lsb_run), .irq(irq)
    );

    sxcv_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(shift), .sample(sample),
        .load_word(txd_wdata), .load_len(len_now), .load_lsb(cfg_lsb_first),
        .run_len(len_run), .run_lsb(lsb_run), .sdi_bit(sdi_bit),
        .sdo_bit(sdo_bit), .rx_word(rx_word)
    );

    // Receive register: updated only by a completed frame with reception on.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rxd_q <= '0;
        else if (done && cfg_rx_en)
            rxd_q <= rx_word;
    end

    // Output pin is driven only inside a frame with transmission enabled.
    always_comb begin
        sdo_pin   = busy & cfg_tx_en & sdo_bit;
        xfer_busy = busy;
        done_irq  = irq;
        rxd_data  = rxd_q;
    end

    assert_sdo_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_busy |-> !sdo_pin);
    assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_irq |-> $stable(rxd_q));
    assert_tx_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_tx_en |-> !sdo_pin);
endmodule

// File: tb/serial_slave_xcvr_tb_top.sv
module serial_slave_xcvr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int SEED       = 1234;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_power = 1'b0, cfg_tx_en = 1'b0, cfg_rx_en = 1'b0, cfg_lsb_first = 1'b0;
    logic [3:0]  cfg_len_code = '0;
    logic        txd_wr = 1'b0;
    logic [15:0] txd_wdata = '0;
    logic [15:0] rxd_data;
    logic        xfer_busy, done_irq;
    logic        sck_pin = 1'b1, sdi_pin = 1'b0;
    logic        sdo_pin;

    int n_checks = 0, n_fail = 0, irq_cnt = 0;
    bit finished = 1'b0;

    logic [15:0] f_tx, f_rx;
    int          f_n;
    bit          f_lsb, f_txen;

    serial_slave_xcvr dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_power(cfg_power), .cfg_tx_en(cfg_tx_en),
        .cfg_rx_en(cfg_rx_en), .cfg_lsb_first(cfg_lsb_first), .cfg_len_code(cfg_len_code),
        .txd_wr(txd_wr), .txd_wdata(txd_wdata), .rxd_data(rxd_data),
        .xfer_busy(xfer_busy), .done_irq(done_irq),
        .sck_pin(sck_pin), .sdi_pin(sdi_pin), .sdo_pin(sdo_pin)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (rst_n && done_irq) irq_cnt++;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int code);
        if (code == 0) return 8;
        if (code > 8) return 16;
        return 8 + code;
    endfunction

    function automatic logic [15:0] len_mask(input int n);
        return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
    endfunction

    function automatic logic pick_bit(input logic [15:0] w, input int i);
        return f_lsb ? w[i] : w[f_n-1-i];
    endfunction

    task automatic wait_clk(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic sck_bit(input logic sdi_val, output logic seen);
        wait_clk(HALF);
        sck_pin = 1'b0;
        sdi_pin = sdi_val;
        wait_clk(HALF);
        seen = sdo_pin;
        sck_pin = 1'b1;
    endtask

    task automatic tx_write(input logic [15:0] d);
        @(negedge clk);
        txd_wdata = d;
        txd_wr = 1'b1;
        @(negedge clk);
        txd_wr = 1'b0;
    endtask

    task automatic start_frame(input logic [15:0] tx, input logic [15:0] rx, input int code,
                               input bit lsb, input bit txen, input bit rxen);
        @(negedge clk);
        cfg_len_code = 4'(code);
        cfg_lsb_first = lsb;
        cfg_tx_en = txen;
        cfg_rx_en = rxen;
        f_tx = tx; f_rx = rx; f_n = exp_len(code); f_lsb = lsb; f_txen = txen;
        tx_write(tx);
        wait_clk(1);
        check(xfer_busy == 1'b1, "R2 busy after write", 32'(xfer_busy), 1);
        check(sdo_pin == (txen ? pick_bit(tx, 0) : 1'b0), "R2 first bit", 32'(sdo_pin),
              32'(txen ? pick_bit(tx, 0) : 1'b0));
    endtask

    task automatic run_bits(input int from, input int upto);
        for (int i = from; i < upto; i++) begin
            logic seen, exp;
            sck_bit(pick_bit(f_rx, i), seen);
            exp = f_txen ? pick_bit(f_tx, i) : 1'b0;
            if (!f_txen)   check(seen == exp, "R10 sdo held low", 32'(seen), 32'(exp));
            else if (f_lsb) check(seen == exp, "R5 lsb-first bit", 32'(seen), 32'(exp));
            else            check(seen == exp, "R4 msb-first bit", 32'(seen), 32'(exp));
        end
    endtask

    task automatic finish_frame(input logic [15:0] prev_rx, input int irq0, input bit rxen);
        logic [15:0] exp;
        wait_clk(6);
        exp = rxen ? (f_rx & len_mask(f_n)) : prev_rx;
        check(xfer_busy == 1'b0, "R6 busy cleared", 32'(xfer_busy), 0);
        check(irq_cnt == irq0 + 1, "R6 single pulse", irq_cnt, irq0 + 1);
        if (rxen) check(rxd_data == exp, f_lsb ? "R5 rx word" : "R4 rx word", rxd_data, exp);
        else      check(rxd_data == exp, "R10 rx not updated", rxd_data, exp);
        check(sdo_pin == 1'b0, "R7 sdo idle", 32'(sdo_pin), 0);
    endtask

    task automatic full_frame(input logic [15:0] tx, input logic [15:0] rx, input int code,
                              input bit lsb, input bit txen, input bit rxen);
        logic [15:0] prev;
        int i0;
        prev = rxd_data;
        i0 = irq_cnt;
        start_frame(tx, rx, code, lsb, txen, rxen);
        run_bits(0, f_n);
        finish_frame(prev, i0, rxen);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] prev;
        int i0, dummy;
        dummy = $urandom(SEED);
        wait_clk(5);
        // R1: reset state
        check(xfer_busy == 0, "R1 busy", 32'(xfer_busy), 0);
        check(done_irq == 0, "R1 irq", 32'(done_irq), 0);
        check(sdo_pin == 0, "R1 sdo", 32'(sdo_pin), 0);
        check(rxd_data == 0, "R1 rx", rxd_data, 0);
        rst_n = 1'b1;
        cfg_power = 1'b1;
        wait_clk(4);
        check(rxd_data == 0 && xfer_busy == 0, "R1 after release", rxd_data, 0);

        // R4/R3: 8-bit MSB first; R5/R3: 16-bit LSB first; R3 clamp
        full_frame(16'h00A5, 16'h003C, 0, 1'b0, 1'b1, 1'b1);
        full_frame(16'hC3E1, 16'h9B27, 8, 1'b1, 1'b1, 1'b1);
        full_frame(16'h1234, 16'hFEDC, 12, 1'b0, 1'b1, 1'b1);
        full_frame(16'h0155, 16'h02AA, 2, 1'b1, 1'b1, 1'b1);

        // R7: edges while idle are ignored
        prev = rxd_data; i0 = irq_cnt;
        for (int k = 0; k < 5; k++) begin
            logic seen;
            sck_bit(1'b1, seen);
            check(seen == 1'b0, "R7 sdo idle under edges", 32'(seen), 0);
        end
        wait_clk(6);
        check(rxd_data == prev, "R7 rx kept", rxd_data, prev);
        check(irq_cnt == i0, "R7 no pulse", irq_cnt, i0);
        check(xfer_busy == 0, "R7 still idle", 32'(xfer_busy), 0);

        // R8: write during a frame is ignored
        prev = rxd_data; i0 = irq_cnt;
        start_frame(16'h00F0, 16'h0081, 0, 1'b0, 1'b1, 1'b1);
        run_bits(0, 2);
        cfg_len_code = 4'd8;
        cfg_lsb_first = 1'b1;
        tx_write(16'hFFFF);
        run_bits(2, f_n);
        finish_frame(prev, i0, 1'b1);
        check(1'b1, "R8 frame kept original word", 0, 0);

        // R9: power off mid-frame, writes ignored while off
        prev = rxd_data; i0 = irq_cnt;
        start_frame(16'hAAAA, 16'h5555, 8, 1'b0, 1'b1, 1'b1);
        run_bits(0, 3);
        @(negedge clk); cfg_power = 1'b0;
        wait_clk(2);
        check(xfer_busy == 0, "R9 busy cleared", 32'(xfer_busy), 0);
        check(sdo_pin == 0, "R9 sdo low", 32'(sdo_pin), 0);
        tx_write(16'h1111);
        wait_clk(2);
        check(xfer_busy == 0, "R9 write ignored", 32'(xfer_busy), 0);
        cfg_power = 1'b1;
        wait_clk(6);
        check(irq_cnt == i0, "R9 no pulse", irq_cnt, i0);
        check(rxd_data == prev, "R9 rx kept", rxd_data, prev);
        check(xfer_busy == 0, "R9 idle after power on", 32'(xfer_busy), 0);

        // R10: each enable held low
        full_frame(16'hFFFF, 16'h0F0F, 4, 1'b0, 1'b0, 1'b1);
        full_frame(16'h6789, 16'hABCD, 6, 1'b1, 1'b1, 1'b0);

        // Random frames across all codes and both orders
        for (int r = 0; r < 40; r++) begin
            full_frame(16'($urandom), 16'($urandom), int'($urandom % 16),
                       1'($urandom % 2), 1'b1, 1'b1);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule